// File: doc/BRIEF.md
# Interval-Spread Pulse Output FIFO

This block sits between a compute engine and two meter pulse pins, one for real energy and one for reactive energy. The engine produces its pulse sign bits in a burst early in each frame. The block catches them in a small queue and plays them out onto the pins at an even, programmable spacing, so the pulses are spread over the frame rather than bunched at its start.

A frame-start strobe empties the queue and restarts the spacing timer. Each write carries one sign bit for each pin. Both bits travel together as a single entry. The timer counts filter-clock enable pulses, and one step of the spacing setting equals four of them. The first release comes one full spacing after the frame starts. A setting of zero turns the queue off, and writes then go straight to the pins. A global invert bit selects the pin polarity: active low by default, active high when set.

Top module: `pls_spread_top`

## Requirements
- R1: After reset the held sign bits are 0. Both pins show the inactive level, which is 1 while invert is 0. The overflow flag is 0.
- R2: With `interval` equal to 0, a write loads its two sign bits into the held state at the next clock edge. Ticks and frame starts have no effect on the pins.
- R3: With `interval` nonzero, a write is queued and does not change the pins at the edge that accepts it.
- R4: After a frame start, the first release happens on the 4*`interval`-th `fir_tick` pulse. The pins show the oldest entry right after the clock edge that samples that tick.
- R5: Later releases come every 4*`interval` tick pulses, in the order the entries were written.
- R6: If the queue is empty at a release time, the pins keep their previous values.
- R7: A frame start discards all queued entries and restarts the tick count from zero.
- R8: The queue holds 8 entries. A ninth write in the same frame, with no release between, is dropped and sets `overflow`. `overflow` stays 1 until reset, including across frame starts.
- R9: Each pin equals the inverse of its held sign bit while `invert` is 0, and equals the bit itself while `invert` is 1. A change of `invert` shows on both pins without waiting for a clock edge.
- R10: Each entry carries the real bit (`wr_act`) and the reactive bit (`wr_rea`), and both pins change at the same edge.
- R11: The spacing timer advances only in cycles where `fir_tick` is 1. Idle cycles between ticks do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| fir_tick | input | 1 | Filter-clock enable pulse |
| interval | input | IW | Spacing setting, in units of 4 ticks; 0 bypasses the queue |
| invert | input | 1 | 1 makes the pins active high |
| wr_en | input | 1 | Write strobe for one sign-bit pair |
| wr_act | input | 1 | Real-energy sign bit |
| wr_rea | input | 1 | Reactive-energy sign bit |
| pulse_act | output | 1 | Real-energy pulse pin |
| pulse_rea | output | 1 | Reactive-energy pulse pin |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench builds the block with DEPTH=8, IW=6 and TICK_MUL=4. These values keep the queue at its specified size, so a ninth write does reach the drop path. Spacing settings of 1 and 2 give release periods of 4 and 8 ticks. A whole frame, including a full queue drained entry by entry, therefore fits in a few hundred cycles. Some sequences leave idle cycles between ticks, which separates counting ticks from counting clocks.

// File: rtl/pls_spread_pkg.sv
package pls_spread_pkg;

  typedef struct packed {
    logic p_act;
    logic p_rea;
  } pls_pair_t;

  // Release period in tick pulses for a given spacing setting.
  function automatic logic [31:0] span_ticks(input logic [31:0] setting,
                                             input int unsigned mul);
    return setting * mul;
  endfunction

  // Pin level from a held sign bit and the polarity select.
  function automatic logic pin_level(input logic sign_bit, input logic inv);
    return sign_bit ^ ~inv;
  endfunction

endpackage

// File: rtl/pls_tick_timer.sv
module pls_tick_timer
  import pls_spread_pkg::*;
#(
  parameter int IW       = 8,
  parameter int TICK_MUL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick_en,
  input  logic [IW-1:0] setting,
  output logic          update_evt,
  output logic          bypass
);
  localparam int CW = IW + $clog2(TICK_MUL) + 1;

  logic [CW-1:0] cnt;
  logic [31:0]   span;
  logic          at_end;

  assign bypass     = (setting == '0);
  assign span       = span_ticks(32'(setting), TICK_MUL);
  assign at_end     = (32'(cnt) >= (span - 32'd1));
  assign update_evt = tick_en && !restart && !bypass && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart)            cnt <= '0;
    else if (tick_en && !bypass) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R11
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt));

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/pls_fifo.sv
module pls_fifo
  import pls_spread_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push,
  input  logic      pop,
  input  pls_pair_t wdata,
  output pls_pair_t rdata,
  output logic      empty,
  output logic      full,
  output logic      drop
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;

  pls_pair_t        mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNTW-1:0]  fill;
  logic             do_pop, do_push;
  logic [DEPTH-1:0] we;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == CNTW'(DEPTH));
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !clr && (!full || do_pop);
  assign drop    = push && !clr && full && !do_pop;
  assign rdata   = mem[rp];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      assign we[i] = clr ? (push && (i == 0)) : (do_push && (wp == AW'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mem[i] <= '0;
        else if (we[i]) mem[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (clr) begin
      rp   <= '0;
      wp   <= push ? AW'(1) : '0;
      fill <= push ? CNTW'(1) : '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      fill <= fill + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNTW'(DEPTH));

  // R8
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> full);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !push) |=> empty);

endmodule

// File: rtl/pls_pin_stage.sv
module pls_pin_stage
  import pls_spread_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  pls_pair_t ldata,
  input  logic      invert,
  output pls_pair_t held,
  output logic      pin_act,
  output logic      pin_rea
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= ldata;
  end

  assign pin_act = pin_level(held.p_act, invert);
  assign pin_rea = pin_level(held.p_rea, invert);

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held));

  // R10
  pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (held == $past(ldata)));

endmodule

// File: rtl/pls_spread_top.sv
module pls_spread_top
  import pls_spread_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int IW       = 8,
  parameter int TICK_MUL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          fir_tick,
  input  logic [IW-1:0] interval,
  input  logic          invert,
  input  logic          wr_en,
  input  logic          wr_act,
  input  logic          wr_rea,
  output logic          pulse_act,
  output logic          pulse_rea,
  output logic          overflow
);
  // Named internal events, visible to the assertions.
  logic      update_evt;
  logic      bypass;
  logic      q_empty, q_full, q_drop;
  logic      pin_load;
  pls_pair_t wr_pair, q_head, pin_data, held;

  assign wr_pair  = '{p_act: wr_act, p_rea: wr_rea};
  assign pin_load = bypass ? wr_en : (update_evt && !q_empty);
  assign pin_data = bypass ? wr_pair : q_head;

  pls_tick_timer #(.IW(IW), .TICK_MUL(TICK_MUL)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (frame_start),
    .tick_en    (fir_tick),
    .setting    (interval),
    .update_evt (update_evt),
    .bypass     (bypass)
  );

  pls_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_start),
    .push  (wr_en && !bypass),
    .pop   (update_evt),
    .wdata (wr_pair),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full),
    .drop  (q_drop)
  );

  pls_pin_stage u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pin_load),
    .ldata   (pin_data),
    .invert  (invert),
    .held    (held),
    .pin_act (pulse_act),
    .pin_rea (pulse_rea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overflow <= 1'b0;
    else if (q_drop) overflow <= 1'b1;
  end

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_drop |=> overflow);

  // R2
  bypass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && wr_en) |=> (held == $past(wr_pair)));

  // R3
  queued_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !update_evt) |=> $stable(held));

endmodule

// File: tb/sim_pls_spread_top.sv
module sim_pls_spread_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW         = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start, fir_tick, invert, wr_en, wr_act, wr_rea;
  logic [IW-1:0] interval;
  logic          pulse_act, pulse_rea, overflow;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [1:0] exp_st;   // {real, reactive} held sign bits as the bench models them

  always #(CLK_PERIOD/2) clk = ~clk;

  pls_spread_top #(.DEPTH(8), .IW(IW), .TICK_MUL(4)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fir_tick(fir_tick),
    .interval(interval), .invert(invert), .wr_en(wr_en), .wr_act(wr_act),
    .wr_rea(wr_rea), .pulse_act(pulse_act), .pulse_rea(pulse_rea),
    .overflow(overflow)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    check2(req, {pulse_act, pulse_rea}, invert ? exp_st : ~exp_st);
  endtask

  task automatic wr(input logic a, input logic r);
    wr_en = 1'b1; wr_act = a; wr_rea = r;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      fir_tick = 1'b1;
      step();
      fir_tick = 1'b0;
      repeat (gap) step();
    end
  endtask

  task automatic fstart();
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  task automatic t_reset();
    exp_st = 2'b00;
    chk_pins("R1 pins idle");
    check2("R1 overflow", {1'b0, overflow}, 2'b00);
  endtask

  task automatic t_bypass();
    interval = '0;
    step();
    wr(1'b1, 1'b0); exp_st = 2'b10;
    chk_pins("R2 bypass write 10");
    wr(1'b0, 1'b1); exp_st = 2'b01;
    chk_pins("R2 bypass write 01");
    ticks(6, 0);
    fstart();
    chk_pins("R2 ticks and frame ignored");
  endtask

  task automatic t_spread();
    interval = 6'd2;   // 8 ticks per release
    fstart();
    wr(1'b1, 1'b1);
    chk_pins("R3 write queued");
    wr(1'b0, 1'b1);
    wr(1'b1, 1'b0);
    chk_pins("R3 pins unchanged");
    ticks(7, 1);
    chk_pins("R4 before first release");
    ticks(1, 1); exp_st = 2'b11;
    chk_pins("R4 R10 first release");
    ticks(7, 2);
    chk_pins("R11 idle cycles not counted");
    ticks(1, 2); exp_st = 2'b01;
    chk_pins("R5 second release");
    ticks(8, 0); exp_st = 2'b10;
    chk_pins("R5 third release");
    ticks(8, 0);
    chk_pins("R6 empty holds");
  endtask

  task automatic t_clear();
    interval = 6'd1;   // 4 ticks per release
    fstart();
    wr(1'b0, 1'b0);
    wr(1'b0, 1'b0);
    ticks(2, 0);
    fstart();
    wr(1'b1, 1'b1);
    ticks(3, 0);
    chk_pins("R7 count restarted");
    ticks(1, 0); exp_st = 2'b11;
    chk_pins("R7 new entry first");
    ticks(4, 0);
    chk_pins("R7 old entries gone");
  endtask

  task automatic t_overflow();
    interval = 6'd1;
    fstart();
    for (int i = 0; i < 8; i++) wr(i[0], i[1]);
    check2("R8 no overflow at 8", {1'b0, overflow}, 2'b00);
    wr(1'b0, 1'b0);
    check2("R8 overflow on ninth", {1'b0, overflow}, 2'b01);
    for (int i = 0; i < 8; i++) begin
      ticks(4, 0);
      exp_st = {i[0], i[1]};
      chk_pins("R8 R5 drain order");
    end
    ticks(4, 0);
    chk_pins("R8 ninth dropped");
    fstart();
    check2("R8 overflow sticky", {1'b0, overflow}, 2'b01);
  endtask

  task automatic t_invert();
    invert = 1'b1;
    #1;
    chk_pins("R9 invert immediate");
    interval = '0;
    step();
    wr(1'b1, 1'b0); exp_st = 2'b10;
    chk_pins("R9 active high write");
    invert = 1'b0;
    #1;
    chk_pins("R9 back to active low");
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; fir_tick = 1'b0; interval = '0;
    invert = 1'b0; wr_en = 1'b0; wr_act = 1'b0; wr_rea = 1'b0;
    exp_st = 2'b00;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_bypass();
    t_spread();
    t_clear();
    t_overflow();
    t_invert();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule